// File: doc/BRIEF.md
# Binary Tree Hop Router

This block decides, for one node of a binary-tree multiprocessor network, which of its links a message should leave on. Node addresses are prefix codes: the root is binary 1, and a child's address is its parent's address with one more bit appended (0 for the left child, 1 for the right child). Each decision depends only on the local node address and the destination node address. No routing table is consulted and no global state is kept.

A request carries the local address, the target address and a routing mode, and it is accepted with a valid/ready handshake. One cycle later the block presents a registered one-hot port vector, or an error flag if an address is malformed. Plain tree mode routes through the common ancestor. The two ring modes may also step sideways to a node on the same level when the target's ancestor at that level is close by. In the full ring the sideways distance wraps around the level. In the half ring only sibling pairs are linked.

Top module: `tree_route_unit`

## Requirements
- R1: While reset is high, req_ready and res_valid are low. From the first cycle after reset is released, req_ready is high.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) gives res_valid high for exactly the following cycle. res_valid is never high without an accepted request. res_port uses bit 0 for local delivery, bit 1 for the parent, bit 2 for the left child, bit 3 for the right child, bit 4 for the left same-level neighbour and bit 5 for the right same-level neighbour. When the result is valid, exactly one port bit is set, or res_err is set and res_port is zero.
- R3: If the local address equals the target address, the result is local delivery (bit 0).
- R4: If the local address is a proper leading-bit prefix of the target, the result is a child link. The target bit directly below the local node's level picks the link: 0 gives the left child (bit 2) and 1 gives the right child (bit 3).
- R5: In tree mode (req_mode 00), and in mode 11 which behaves the same way, a target that neither equals nor extends the local address is sent to the parent (bit 1).
- R6: In full-ring mode (req_mode 10), a node's level is the index of its leading one. Take the target's ancestor at the local level, found by shifting the target right by the difference in levels, and suppose it is not the local node. Let f be its forward distance and b its backward distance, both wrapped modulo the level width. If f is between 1 and 4 and f <= b, the result is the right neighbour (bit 5). Otherwise, if b is between 1 and 4, the result is the left neighbour (bit 4). Otherwise the R5 rule applies. The root never goes sideways.
- R7: In half-ring mode (req_mode 01), a sideways link exists only between the two children of one parent. The result is bit 5 when the local node is a left child and the ancestor is its right sibling, and bit 4 when the local node is a right child and the ancestor is its left sibling. Otherwise the R5 rule applies.
- R8: An all-zero local or target address, or an address whose level exceeds MAX_LVL, sets res_err with res_port zero.
- R9: Following the hops one by one from any node to any node reaches the target. In tree modes the walk takes exactly the up-then-down length, and in ring modes it is never longer than that.
- R10: In modes 00 and 11 the sideways bits 4 and 5 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_local | input | ADDR_W | Address of the node making the decision |
| req_target | input | ADDR_W | Destination node address |
| req_mode | input | 2 | 00 tree, 01 half ring, 10 full ring, 11 tree |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_port | output | 6 | One-hot selected link |
| res_err | output | 1 | Malformed address in the accepted request |

## Verification
The two functions that can fall in the same cycle are presenting the result of one request and accepting the next. The bench provokes this on every hop of its walks: it drives the next hop's addresses in the same cycle that it reads the previous hop's port, so the register stage must hold each result for exactly one cycle without disturbing the next. Each hop is judged against an arithmetic model of the rules in a 6-level tree. Each full walk is judged on whether it arrives, and on its length compared with the pure tree path.

// File: rtl/tru_pkg.sv
package tru_pkg;
  typedef enum logic [1:0] {
    MODE_TREE = 2'd0,
    MODE_HALF = 2'd1,
    MODE_FULL = 2'd2,
    MODE_ALT  = 2'd3
  } route_mode_e;

  localparam int N_PORTS  = 6;
  localparam int P_LOCAL  = 0;
  localparam int P_UP     = 1;
  localparam int P_DN_L   = 2;
  localparam int P_DN_R   = 3;
  localparam int P_SIDE_L = 4;
  localparam int P_SIDE_R = 5;
  localparam int SPAN_LIM = 4;
endpackage

// File: rtl/tru_level.sv
module tru_level #(
  parameter int W  = 16,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  addr,
  output logic [LW-1:0] lvl,
  output logic          zero
);
  // leading-one position = tree level
  always_comb begin
    lvl = '0;
    for (int i = 0; i < W; i++) begin
      if (addr[i]) lvl = LW'(i);
    end
    zero = (addr == '0);
  end
endmodule

// File: rtl/tru_decide.sv
module tru_decide
  import tru_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAX_LVL = W - 1,
  parameter int LW      = $clog2(W)
) (
  input  logic [W-1:0]       loc,
  input  logic [W-1:0]       tgt,
  input  logic [1:0]         mode,
  output logic [N_PORTS-1:0] port,
  output logic               err
);
  logic [LW-1:0] lvl_l, lvl_t, dl;
  logic          zero_l, zero_t;

  tru_level #(.W(W), .LW(LW)) u_lvl_loc (.addr(loc), .lvl(lvl_l), .zero(zero_l));
  tru_level #(.W(W), .LW(LW)) u_lvl_tgt (.addr(tgt), .lvl(lvl_t), .zero(zero_t));

  route_mode_e rmode;
  logic [W-1:0] anc, width_m, pos_l, pos_a, fwd, back;
  logic deeper, is_pref, below, side_ok;
  logic full_r, full_l, half_r, half_l, bad;

  always_comb begin
    rmode   = route_mode_e'(mode);
    deeper  = (lvl_t >= lvl_l);
    dl      = lvl_t - lvl_l;
    anc     = tgt >> dl;
    below   = tgt[dl - LW'(1)];
    is_pref = deeper && (dl != '0) && (anc == loc);
    width_m = (W'(1) << lvl_l) - W'(1);
    pos_l   = loc & width_m;
    pos_a   = anc & width_m;
    fwd     = (pos_a - pos_l) & width_m;
    back    = (pos_l - pos_a) & width_m;
    side_ok = deeper && (lvl_l != '0) && (anc != loc);
    full_r  = (fwd != '0) && (fwd <= W'(SPAN_LIM)) && (fwd <= back);
    full_l  = !full_r && (back != '0) && (back <= W'(SPAN_LIM));
    half_r  = !pos_l[0] && (pos_a == pos_l + W'(1));
    half_l  = pos_l[0] && (pos_a + W'(1) == pos_l);
    bad     = zero_l || zero_t || (lvl_l > LW'(MAX_LVL)) || (lvl_t > LW'(MAX_LVL));

    port = '0;
    err  = 1'b0;
    if (bad) begin
      err = 1'b1;
    end else if (loc == tgt) begin
      port[P_LOCAL] = 1'b1;
    end else if (is_pref) begin
      if (below) port[P_DN_R] = 1'b1;
      else       port[P_DN_L] = 1'b1;
    end else if (rmode == MODE_FULL && side_ok && full_r) begin
      port[P_SIDE_R] = 1'b1;
    end else if (rmode == MODE_FULL && side_ok && full_l) begin
      port[P_SIDE_L] = 1'b1;
    end else if (rmode == MODE_HALF && side_ok && half_r) begin
      port[P_SIDE_R] = 1'b1;
    end else if (rmode == MODE_HALF && side_ok && half_l) begin
      port[P_SIDE_L] = 1'b1;
    end else begin
      port[P_UP] = 1'b1;
    end
  end
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tru_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LVL = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_local,
  input  logic [ADDR_W-1:0] req_target,
  input  logic [1:0]        req_mode,
  output logic              res_valid,
  output logic [5:0]        res_port,
  output logic              res_err
);
  localparam int LW = $clog2(ADDR_W);

  logic [N_PORTS-1:0] dec_port;
  logic               dec_err;
  logic               accept;

  tru_decide #(.W(ADDR_W), .MAX_LVL(MAX_LVL), .LW(LW)) u_decide (
    .loc (req_local),
    .tgt (req_target),
    .mode(req_mode),
    .port(dec_port),
    .err (dec_err)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      res_valid <= 1'b0;
      res_port  <= '0;
      res_err   <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      res_valid <= accept;
      if (accept) begin
        res_port <= dec_port;
        res_err  <= dec_err;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !req_ready));

  p_resp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid && req_ready));

  p_port_or_err_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_err && res_port == '0) || (!res_err && $countones(res_port) == 1)));

  p_local_match_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_err) |-> (res_port[P_LOCAL] == $past(req_local == req_target)));

  p_tree_no_side_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(req_mode[1] == req_mode[0])) |-> (!res_port[P_SIDE_L] && !res_port[P_SIDE_R]));
endmodule

// File: tb/tree_route_unit_bench.sv
`timescale 1ns/1ps
module tree_route_unit_bench;
  localparam int AW   = 8;
  localparam int MAXL = 6;
  localparam int TOPN = (1 << (MAXL + 1)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_local = '0;
  logic [AW-1:0] req_target = '0;
  logic [1:0]    req_mode = '0;
  logic          res_valid;
  logic [5:0]    res_port;
  logic          res_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  tree_route_unit #(.ADDR_W(AW), .MAX_LVL(MAXL)) u_tree_route_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_local(req_local), .req_target(req_target), .req_mode(req_mode),
    .res_valid(res_valid), .res_port(res_port), .res_err(res_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int a);
    int l = 0;
    for (int i = 0; i < 31; i++) if ((a >> i) & 1) l = i;
    return l;
  endfunction

  // returns port index, -1 for error
  function automatic int model(input int loc, input int tgt, input int mode);
    int ll = lvl_of(loc);
    int lt = lvl_of(tgt);
    if (loc == 0 || tgt == 0 || ll > MAXL || lt > MAXL) return -1;
    if (loc == tgt) return 0;
    if (lt > ll && (tgt >> (lt - ll)) == loc) return ((tgt >> (lt - ll - 1)) & 1) ? 3 : 2;
    if (lt >= ll && ll > 0) begin
      int n  = 1 << ll;
      int pl = loc - n;
      int pa = (tgt >> (lt - ll)) - n;
      if (mode == 2) begin
        int f = ((pa - pl) % n + n) % n;
        int b = (n - f) % n;
        if (f > 0 && f < 5 && f <= b) return 5;
        if (b > 0 && b < 5) return 4;
      end
      if (mode == 1) begin
        if (pa == pl + 1 && pl % 2 == 0) return 5;
        if (pa == pl - 1 && pl % 2 == 1) return 4;
      end
    end
    return 1;
  endfunction

  function automatic int step(input int cur, input int p, input int mode);
    int l = lvl_of(cur);
    int n = 1 << l;
    int pos = cur - n;
    case (p)
      1: return cur >> 1;
      2: return cur * 2;
      3: return cur * 2 + 1;
      4: return (mode == 2) ? ((pos - 1 + n) % n) + n : cur - 1;
      5: return (mode == 2) ? ((pos + 1) % n) + n : cur + 1;
      default: return cur;
    endcase
  endfunction

  function automatic int tree_len(input int s, input int t);
    int c = s;
    int k = 0;
    int lt = lvl_of(t);
    while (!(lvl_of(c) <= lt && (t >> (lt - lvl_of(c))) == c)) begin
      c = c >> 1;
      k++;
    end
    return k + lt - lvl_of(c);
  endfunction

  function automatic int idx_of(input logic [5:0] v, input logic e);
    if (e) return (v == 0) ? -1 : -2;
    for (int i = 0; i < 6; i++) if (v == 6'(1 << i)) return i;
    return -3;
  endfunction

  // drive at a negedge; accepted at next posedge; sampled at following negedge
  task automatic hop(input int loc, input int tgt, input int mode, output int got);
    req_local  = AW'(loc);
    req_target = AW'(tgt);
    req_mode   = 2'(mode);
    req_valid  = 1'b1;
    @(negedge clk);
    chk(res_valid === 1'b1, "R2 res_valid after accept", int'(res_valid), 1);
    got = idx_of(res_port, res_err);
  endtask

  task automatic walk(input int s, input int t, input int mode);
    int cur = s;
    int hops = 0;
    int got;
    int exp;
    bit done = 0;
    string tag;
    while (!done && hops < 40) begin
      hop(cur, t, mode, got);
      exp = model(cur, t, mode);
      if (exp == 0) tag = "R3 local";
      else if (exp == 2 || exp == 3) tag = "R4 descend";
      else if (exp == 1) tag = "R5 parent";
      else if (mode == 2) tag = "R6 full ring side";
      else tag = "R7 half ring side";
      chk(got == exp, tag, got, exp);
      if (mode == 0 || mode == 3) chk(got != 4 && got != 5, "R10 tree no side", got, 1);
      if (got == 0 || got != exp) done = 1;
      else begin
        cur = step(cur, got, mode);
        hops++;
      end
    end
    chk(cur == t, "R9 walk arrives", cur, t);
    if (mode == 1 || mode == 2)
      chk(hops <= tree_len(s, t), "R9 ring not longer", hops, tree_len(s, t));
    else
      chk(hops == tree_len(s, t), "R9 tree length", hops, tree_len(s, t));
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int got;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b0, "R1 ready low in reset", int'(req_ready), 0);
    chk(res_valid === 1'b0, "R1 valid low in reset", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(res_valid === 1'b0, "R2 no result without request", int'(res_valid), 0);

    // malformed addresses
    hop(0, 5, 0, got);   chk(got == -1, "R8 zero local", got, -1);
    hop(5, 0, 2, got);   chk(got == -1, "R8 zero target", got, -1);
    hop(3, 'h80, 1, got); chk(got == -1, "R8 target too deep", got, -1);
    hop('h80, 3, 0, got); chk(got == -1, "R8 local too deep", got, -1);
    // full ring wrap across level edge: 15 -> 8 forward distance 1
    hop(15, 8, 2, got);  chk(got == 5, "R6 wrap right", got, 5);
    hop(8, 15, 2, got);  chk(got == 4, "R6 wrap left", got, 4);
    // half ring: no link across parents
    hop(5, 6, 1, got);   chk(got == 1, "R7 no cross-parent link", got, 1);
    hop(4, 5, 1, got);   chk(got == 5, "R7 sibling link", got, 5);
    req_valid = 1'b0;
    @(negedge clk);
    chk(res_valid === 1'b0, "R2 single-cycle result", int'(res_valid), 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 1; s <= TOPN; s++) begin
        for (int k = 0; k < ((m == 3) ? 2 : 16); k++) begin
          walk(s, ((s * 37 + k * 53 + m * 11 + k * k * 7) % TOPN) + 1, m);
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule